// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the clock waveform of an I2C master and marks the moments at which the data line may change. A packed 32-bit timing word sets five values: a prescaler, a setup delay, a hold delay, a high count and a low count. A separate filter coefficient sets how many extra kernel clocks the bus synchroniser adds. The prescaler gives a time base of (prescaler+1) kernel clocks, and every period in the word is a whole number of these time-base periods. The block drives SCL low for the low phase and releases it for the high phase. It raises a one-cycle data-update strobe once in every low phase.

The high phase starts counting only after the synchronised SCL input has been seen high. A slave that holds the clock low therefore stretches the high phase. The timing word and the filter coefficient are captured only while the enable input is low. Dropping enable releases SCL and returns the phase counters to idle. Start and stop conditions, byte framing, input filtering and register decoding belong to the surrounding controller.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: While reset is asserted or enable is low, `scl_drive_low` and `sda_update` are 0. After enable is sampled low at a clock edge, both are 0 from the next cycle on.
- R2: The timing word and the filter coefficient are captured on every clock edge at which enable is low. Changes made while enable is high do not affect any phase length until enable has gone low and then high again.
- R3: With T = PRESC+1 and S = 2 + effective filter coefficient, each low phase lasts max(S + (SCLL+1)·T, SDADEL·T + 1 + (SCLDEL+1)·T) kernel clocks.
- R4: Each high phase lasts W + S + (SCLH+1)·T kernel clocks. W is the number of released cycles in which `scl_in` is still low before it is first seen high.
- R5: `sda_update` pulses for exactly one cycle in each low phase. The pulse comes SDADEL·T + 1 cycles after the first low cycle, which counts as cycle 0.
- R6: The data-update strobe comes at least (SCLDEL+1)·T cycles before SCL is released.
- R7: While `scl_in` is low and has not yet been seen high in the current high phase, the high-phase count does not advance (clock stretching).
- R8: A filter coefficient above 16 counts as 16.
- R9: Dropping enable in the middle of a phase releases SCL in the next cycle. Enabling again starts a complete, fresh low phase.
- R10: Field positions in the timing word: PRESC is bits 31:28, SCLDEL is bits 23:20, SDADEL is bits 19:16, SCLH is bits 15:8 and SCLL is bits 7:0. Bits 27:24 are ignored.
- R11: The first low phase starts in the cycle right after the clock edge at which enable is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run when high; capture configuration and idle when low |
| cfg_word | input | 32 | Packed timing word (field positions in R10) |
| filt_coef | input | 5 | Digital filter coefficient, 0 to 16 |
| scl_in | input | 1 | Synchronised SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| sda_update | output | 1 | One-cycle strobe: SDA may change now |

## Verification
The embedded properties check several rules on every cycle. SCL is released after enable drops. The captured lengths stay frozen while the block runs. The low-phase counter stays in bounds. The strobe is never longer than one cycle. A stretched high phase holds its count, and the first low cycle follows enable. The exact phase lengths cannot be seen by any single-cycle property: the max rule for the low phase, the strobe position, the stretch-extended high phase and the filter clamp. These are shown only by the bench sweeps, which compare measured cycle counts against arithmetic over the field values.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

   // field placement inside the packed timing word
   localparam int PRESC_LSB  = 28;
   localparam int PRESC_W    = 4;
   localparam int SETUP_LSB  = 20;
   localparam int HOLD_LSB   = 16;
   localparam int DEL_W      = 4;
   localparam int HIGH_LSB   = 8;
   localparam int LOW_LSB    = 0;
   localparam int PER_W      = 8;
   localparam int SYNC_BASE  = 2;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_t;

endpackage

// File: rtl/tg_cfg_latch.sv
module tg_cfg_latch
   import i2c_tg_pkg::*;
#(
   parameter int FILT_MAX = 16,
   parameter int FILT_W   = 5,
   parameter int CNT_W    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [31:0]       cfg_word,
   input  logic [FILT_W-1:0] filt_coef,
   output logic [CNT_W-1:0]  low_len,
   output logic [CNT_W-1:0]  high_len,
   output logic [CNT_W-1:0]  hold_at
);

   initial begin
      assert (FILT_MAX >= 0 && FILT_MAX < (1 << FILT_W))
         else $error("FILT_MAX does not fit FILT_W");
   end

   logic [FILT_W-1:0] filt_eff;
   logic [CNT_W-1:0]  tbase, sync_len, low_by_count, low_by_setup;
   logic [CNT_W-1:0]  low_n, high_n, hold_n;
   logic              unused_rsvd;

   assign unused_rsvd = ^cfg_word[27:24];

   always_comb begin
      filt_eff     = (filt_coef > FILT_W'(FILT_MAX)) ? FILT_W'(FILT_MAX) : filt_coef;
      tbase        = CNT_W'(cfg_word[PRESC_LSB +: PRESC_W]) + CNT_W'(1);
      sync_len     = CNT_W'(SYNC_BASE) + CNT_W'(filt_eff);
      low_by_count = sync_len + (CNT_W'(cfg_word[LOW_LSB +: PER_W]) + CNT_W'(1)) * tbase;
      hold_n       = CNT_W'(cfg_word[HOLD_LSB +: DEL_W]) * tbase + CNT_W'(1);
      low_by_setup = hold_n + (CNT_W'(cfg_word[SETUP_LSB +: DEL_W]) + CNT_W'(1)) * tbase;
      low_n        = (low_by_count > low_by_setup) ? low_by_count : low_by_setup;
      high_n       = sync_len + (CNT_W'(cfg_word[HIGH_LSB +: PER_W]) + CNT_W'(1)) * tbase;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         // lengths of an all-zero word
         low_len  <= CNT_W'(3);
         high_len <= CNT_W'(3);
         hold_at  <= CNT_W'(1);
      end else if (!enable) begin
         low_len  <= low_n;
         high_len <= high_n;
         hold_at  <= hold_n;
      end
   end

   assert_frozen_while_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> ($stable(low_len) && $stable(high_len) && $stable(hold_at)));

endmodule

// File: rtl/tg_phase_seq.sv
module tg_phase_seq
   import i2c_tg_pkg::*;
#(
   parameter int CNT_W      = 13,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             scl_in,
   input  logic [CNT_W-1:0] low_len,
   input  logic [CNT_W-1:0] high_len,
   input  logic [CNT_W-1:0] hold_at,
   output logic             scl_drive_low,
   output logic             sda_update
);

   initial begin
      assert (CNT_W >= 2) else $error("CNT_W too small");
   end

   phase_t           phase_q;
   logic [CNT_W-1:0] elapsed_q;
   logic             seen_high_q;
   logic             high_go;

   generate
      if (STRETCH_EN) begin : g_stretch
         assign high_go = seen_high_q | scl_in;
      end else begin : g_fixed
         logic unused_scl;
         assign unused_scl = scl_in ^ seen_high_q;
         assign high_go    = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         elapsed_q   <= '0;
         seen_high_q <= 1'b0;
      end else if (!enable) begin
         phase_q     <= PH_IDLE;
         elapsed_q   <= '0;
         seen_high_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               phase_q   <= PH_LOW;
               elapsed_q <= '0;
            end
            PH_LOW: begin
               if (elapsed_q == low_len - CNT_W'(1)) begin
                  phase_q   <= PH_HIGH;
                  elapsed_q <= '0;
               end else begin
                  elapsed_q <= elapsed_q + CNT_W'(1);
               end
            end
            PH_HIGH: begin
               if (high_go) begin
                  seen_high_q <= 1'b1;
                  if (elapsed_q == high_len - CNT_W'(1)) begin
                     phase_q     <= PH_LOW;
                     elapsed_q   <= '0;
                     seen_high_q <= 1'b0;
                  end else begin
                     elapsed_q <= elapsed_q + CNT_W'(1);
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign scl_drive_low = (phase_q == PH_LOW);
   assign sda_update    = (phase_q == PH_LOW) && (elapsed_q == hold_at);

   assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_drive_low && !sda_update));

   assert_low_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_LOW) |-> (elapsed_q < low_len));

   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sda_update |=> !sda_update);

   assert_first_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && enable) |=> scl_drive_low);

   generate
      if (STRETCH_EN) begin : g_stretch_chk
         assert_stretch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && phase_q == PH_HIGH && !seen_high_q && !scl_in)
               |=> (phase_q == PH_HIGH && elapsed_q == '0));
      end
   endgenerate

endmodule

// File: rtl/i2c_scl_timing_gen.sv
module i2c_scl_timing_gen
   import i2c_tg_pkg::*;
#(
   parameter  int FILT_MAX   = 16,
   parameter  bit STRETCH_EN = 1'b1,
   localparam int FILT_W     = $clog2(FILT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [31:0]       cfg_word,
   input  logic [FILT_W-1:0] filt_coef,
   input  logic              scl_in,
   output logic              scl_drive_low,
   output logic              sda_update
);

   localparam int TB_MAX  = 1 << PRESC_W;
   localparam int LOW_MAX = SYNC_BASE + FILT_MAX + (1 << PER_W) * TB_MAX;
   localparam int SET_MAX = ((1 << DEL_W) - 1) * TB_MAX + 1 + (1 << DEL_W) * TB_MAX;
   localparam int LEN_MAX = (LOW_MAX > SET_MAX) ? LOW_MAX : SET_MAX;
   localparam int CNT_W   = $clog2(LEN_MAX + 1);

   logic [CNT_W-1:0] low_len, high_len, hold_at;

   tg_cfg_latch #(
      .FILT_MAX (FILT_MAX),
      .FILT_W   (FILT_W),
      .CNT_W    (CNT_W)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .cfg_word  (cfg_word),
      .filt_coef (filt_coef),
      .low_len   (low_len),
      .high_len  (high_len),
      .hold_at   (hold_at)
   );

   tg_phase_seq #(
      .CNT_W      (CNT_W),
      .STRETCH_EN (STRETCH_EN)
   ) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .scl_in        (scl_in),
      .low_len       (low_len),
      .high_len      (high_len),
      .hold_at       (hold_at),
      .scl_drive_low (scl_drive_low),
      .sda_update    (sda_update)
   );

endmodule

// File: tb/test_i2c_scl_timing_gen.sv
`timescale 1ns/1ps
module test_i2c_scl_timing_gen;

   logic        clk = 1'b0;
   logic        rst_n, enable, scl_in, drv, sda;
   logic [31:0] cfg;
   logic [4:0]  filt;
   int          rel_cnt = 0;
   int          stretch_amt = 0;
   int          n_chk = 0;
   int          n_fail = 0;

   always #4 clk = ~clk;

   i2c_scl_timing_gen i_i2c_scl_timing_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .cfg_word      (cfg),
      .filt_coef     (filt),
      .scl_in        (scl_in),
      .scl_drive_low (drv),
      .sda_update    (sda)
   );

   // bus model: slave keeps SCL low for stretch_amt released cycles
   always @(posedge clk) begin
      if (drv) rel_cnt <= 0;
      else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
   end
   assign scl_in = !drv && (rel_cnt >= stretch_amt);

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mkword(int p, int c, int d, int h, int l);
      return {p[3:0], 4'h0, c[3:0], d[3:0], h[7:0], l[7:0]};
   endfunction

   function automatic int eff_f(int f);
      return (f > 16) ? 16 : f;
   endfunction

   function automatic int exp_low(int p, int l, int c, int d, int f);
      int t = p + 1;
      int a = 2 + eff_f(f) + (l + 1) * t;
      int b = d * t + 1 + (c + 1) * t;
      return (a > b) ? a : b;
   endfunction

   function automatic int exp_high(int p, int h, int f, int s);
      return s + 2 + eff_f(f) + (h + 1) * (p + 1);
   endfunction

   task automatic start_run(input logic [31:0] w, input int f);
      @(negedge clk);
      enable = 1'b0;
      cfg    = w;
      filt   = 5'(f);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      check("R11 first low cycle after enable", int'(drv), 1);
   endtask

   // starts on the first low cycle, ends on the first low cycle of the next period
   task automatic measure(output int lo, output int hi, output int pos, output int cnt);
      lo = 0; hi = 0; pos = -1; cnt = 0;
      while (drv && lo < 20000) begin
         if (sda) begin pos = lo; cnt++; end
         lo++;
         @(negedge clk);
      end
      while (!drv && hi < 20000) begin
         hi++;
         @(negedge clk);
      end
   endtask

   task automatic run_cfg(input int p, input int l, input int h, input int c,
                          input int d, input int f, input int s, input logic [3:0] junk);
      int lo, hi, pos, cnt;
      stretch_amt = s;
      start_run(mkword(p, c, d, h, l) | {4'h0, junk, 24'h0}, f);
      for (int k = 0; k < 2; k++) begin
         measure(lo, hi, pos, cnt);
         check("R3 R10 R8 low phase length", lo, exp_low(p, l, c, d, f));
         check("R5 strobe count", cnt, 1);
         check("R5 strobe position", pos, d * (p + 1) + 1);
         check("R6 setup before release", int'((lo - pos) >= (c + 1) * (p + 1)), 1);
         check("R4 R7 high phase length", hi, exp_high(p, h, f, s));
      end
   endtask

   initial begin
      int lo, hi, pos, cnt;
      rst_n = 1'b0; enable = 1'b0; cfg = '0; filt = '0;
      repeat (3) begin
         @(negedge clk);
         check("R1 released in reset", int'(drv | sda), 0);
      end
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R1 released while disabled", int'(drv | sda), 0);
      end

      // sweep of small configurations
      for (int i = 0; i < 128; i++) begin
         run_cfg(i & 3, ((i >> 2) & 1) ? 3 : 0, ((i >> 3) & 1) ? 2 : 0,
                 ((i >> 4) & 1) ? 5 : 0, ((i >> 5) & 1) ? 3 : 0,
                 ((i >> 6) & 1) ? 5 : 0, (i % 5 == 0) ? 2 : 0, 4'h0);
      end

      // setup-dominated low phase (R6), ignored bits set (R10)
      run_cfg(1, 0, 0, 15, 15, 0, 0, 4'h0);
      run_cfg(2, 3, 1, 2, 3, 0, 0, 4'hF);
      // filter clamp (R8)
      run_cfg(0, 1, 1, 0, 0, 16, 0, 4'h0);
      run_cfg(0, 1, 1, 0, 0, 20, 0, 4'h0);
      run_cfg(1, 2, 2, 0, 0, 31, 0, 4'h0);
      // long stretch (R7)
      run_cfg(1, 1, 1, 0, 0, 0, 9, 4'h0);
      // largest counts
      run_cfg(15, 255, 255, 15, 15, 16, 0, 4'h0);

      // R2: word change while enabled is ignored
      stretch_amt = 0;
      start_run(mkword(1, 0, 1, 2, 3), 0);
      cfg  = mkword(3, 4, 4, 9, 9);
      filt = 5'd7;
      measure(lo, hi, pos, cnt);
      check("R2 low unchanged while enabled", lo, exp_low(1, 3, 0, 1, 0));
      check("R2 high unchanged while enabled", hi, exp_high(1, 2, 0, 0));
      start_run(mkword(3, 4, 4, 9, 9), 7);
      measure(lo, hi, pos, cnt);
      check("R2 new low after re-enable", lo, exp_low(3, 9, 4, 4, 7));
      check("R2 new high after re-enable", hi, exp_high(3, 9, 7, 0));

      // R9: disable mid low phase
      start_run(mkword(2, 0, 0, 1, 20), 0);
      repeat (5) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check("R9 R1 released after disable", int'(drv | sda), 0);
      repeat (3) begin
         @(negedge clk);
         check("R9 stays released", int'(drv | sda), 0);
      end
      enable = 1'b1;
      @(negedge clk);
      check("R9 restart low", int'(drv), 1);
      measure(lo, hi, pos, cnt);
      check("R9 full fresh low phase", lo, exp_low(2, 20, 0, 0, 0));
      check("R9 strobe after restart", pos, 1);

      @(negedge clk);
      enable = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule